// File: doc/BRIEF.md
# Refresh Row Counter March Sequencer

This engine checks that the hidden row counter a pseudo-static memory uses for its self-timed refresh walks every row exactly once per lap. It cannot read that counter. Instead it issues commands to a host memory controller and runs a fixed march on a sequence of five steps:

- It fills the whole array with a background value using ordinary writes.
- It performs one lap of counter-addressed cycles. In each cycle the device reads the cell at (counter row, column 0), then writes the inverted value back, and the counter moves on by one row.
- It reads every column-zero cell with ordinary reads to confirm that each one was inverted.
- It runs a second lap that restores the original value.
- It verifies the column-zero cells a second time.

The whole five-step sequence then repeats with the complemented background. A counter that skips a row, stalls, or visits a row twice leaves a cell with the wrong value, or returns one. The first mismatch stops the run and records where it happened.

Software or a test controller pulses `start` while the engine is idle and waits for `done`. The engine reports the result through `pass` and the `fail_*` fields. The mapping from row and column to a linear address is a parameter, so the engine can match the wiring of the device.

Top module: `rcm_march_top`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `cmd_valid` are low, and they stay low until `start` is pulsed.
- R2: `cmd_kind` encodes the command: 0 is a normal write, 1 is a normal read, and 2 is a counter test cycle (read, then write the same cell). Value 3 is never issued. A run begins with step 1, which writes the phase data to every linear address from 0 to 2^(ROW_BITS+COL_BITS)-1 in ascending order. The phase data is BACKGROUND in phase 0 and ~BACKGROUND in phase 1.
- R3: Step 2 issues exactly 2^ROW_BITS counter test cycles. Each cycle has `cmd_addr` = 0, expects the phase data and writes the inverted phase data.
- R4: Step 3 issues normal reads for rows 0 to 2^ROW_BITS-1 in ascending order at column 0 and expects the inverted phase data. When ROW_HIGH=1, the column-zero address is {row, COL_BITS zeros}. When ROW_HIGH=0, it is {COL_BITS zeros, row}.
- R5: Step 4 issues 2^ROW_BITS counter test cycles that expect the inverted data and write the phase data. Step 5 then reads the column-zero cells as in step 3 and expects the phase data.
- R6: After step 5 of phase 0, the five steps run again as phase 1 with complemented data. When phase 1 completes, every cell holds ~BACKGROUND.
- R7: The first response that differs from the expected value ends the run. After that response no further command is issued, and the engine reports `done`=1, `pass`=0, `fail_step` (1 to 5), `fail_phase`, `fail_index` (the iteration within the step) and `fail_data` (the value read). These hold until the next `start`.
- R8: A run with no mismatch issues exactly 2·(2^(ROW_BITS+COL_BITS) + 4·2^ROW_BITS) commands and ends with `done`=1, `pass`=1 and `fail_step`=0.
- R9: A `start` pulse while `busy` is high is ignored, and the command stream continues unchanged.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command and its payload stay stable.
- R11: After a read or counter test cycle has been accepted, no new command is offered until `rsp_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (acted on when not busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; result valid |
| pass | output | 1 | Run finished with no mismatch |
| fail_phase | output | 1 | Phase of the first mismatch |
| fail_step | output | 3 | Step (1..5) of the first mismatch, 0 if none |
| fail_index | output | ROW_BITS+COL_BITS | Iteration index of the first mismatch |
| fail_data | output | DATA_W | Value read at the first mismatch |
| cmd_valid | output | 1 | Command offered to the host controller |
| cmd_ready | input | 1 | Host controller accepts the command |
| cmd_kind | output | 2 | 0 write, 1 read, 2 counter test cycle |
| cmd_addr | output | ROW_BITS+COL_BITS | Linear address (0 for counter cycles) |
| cmd_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | Read data returned for the outstanding command |
| rsp_rdata | input | DATA_W | Returned read data |

## Verification
The bench models a host controller. The model holds a free-running row counter with a random start row, a configurable stride, injectable stuck bits and random ready and response delays. The fault cases are chosen so that a counter that repeats a row, a counter that stalls, and stuck bits in column zero each fail at a precise step, phase and iteration. For example, a stuck-at-1 bit must surface in step 2 at iteration (faulty row − start row) mod rows. An engine that counted iterations wrongly, compared against the wrong polarity or kept going after a mismatch would report a different index or issue extra commands. A stuck bit in a cell outside column zero must not fail the run. A `start` pulse in the middle of a run must not restart the command stream. The final memory image must be all complemented background, which proves that phase 1 really used inverted data.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_CTR   = 2'd2
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_FILL  = 3'd1,
        ST_CTR_A = 3'd2,
        ST_CHK_A = 3'd3,
        ST_CTR_B = 3'd4,
        ST_CHK_B = 3'd5
    } step_e;

    typedef enum logic [1:0] {
        FSM_IDLE,
        FSM_ISSUE,
        FSM_WAIT,
        FSM_DONE
    } fsm_e;

    function automatic cmd_kind_e step_kind(step_e s);
        case (s)
            ST_FILL:            return KIND_WRITE;
            ST_CTR_A, ST_CTR_B: return KIND_CTR;
            default:            return KIND_READ;
        endcase
    endfunction

    // Write data is the inverted phase pattern only in the first counter lap.
    function automatic logic wdata_inverted(step_e s);
        return s == ST_CTR_A;
    endfunction

    // Expected read value is inverted after the first lap until the second lap restores it.
    function automatic logic expect_inverted(step_e s);
        return (s == ST_CHK_A) || (s == ST_CTR_B);
    endfunction

    function automatic step_e next_step(step_e s);
        case (s)
            ST_FILL:  return ST_CTR_A;
            ST_CTR_A: return ST_CHK_A;
            ST_CHK_A: return ST_CTR_B;
            ST_CTR_B: return ST_CHK_B;
            default:  return ST_FILL;
        endcase
    endfunction

endpackage

// File: rtl/rcm_index_ctr.sv
module rcm_index_ctr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    input  logic [W-1:0] last,
    output logic [W-1:0] value,
    output logic         at_last
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    assign at_last = (value == last);
endmodule

// File: rtl/rcm_addr_map.sv
module rcm_addr_map
    import rcm_pkg::*;
#(
    parameter int ROW_BITS = 8,
    parameter int COL_BITS = 7,
    parameter bit ROW_HIGH = 1'b1,
    localparam int ADDR_W  = ROW_BITS + COL_BITS
) (
    input  logic [ADDR_W-1:0] idx,
    input  cmd_kind_e         kind,
    input  logic              linear,
    output logic [ADDR_W-1:0] addr
);
    logic [ROW_BITS-1:0] row;
    logic [ADDR_W-1:0]   col0_addr;

    assign row = idx[ROW_BITS-1:0];

    generate
        if (ROW_HIGH) begin : g_row_high
            assign col0_addr = {row, {COL_BITS{1'b0}}};
        end else begin : g_row_low
            assign col0_addr = {{COL_BITS{1'b0}}, row};
        end
    endgenerate

    always_comb begin
        if (kind == KIND_CTR) begin
            addr = '0;
        end else if (linear) begin
            addr = idx;
        end else begin
            addr = col0_addr;
        end
    end
endmodule

// File: rtl/rcm_pattern.sv
module rcm_pattern #(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] BACKGROUND = '0
) (
    input  logic              phase,
    input  logic              invert,
    output logic [DATA_W-1:0] value
);
    assign value = (phase ^ invert) ? ~BACKGROUND : BACKGROUND;
endmodule

// File: rtl/rcm_march_top.sv
module rcm_march_top
    import rcm_pkg::*;
#(
    parameter int                ROW_BITS   = 8,
    parameter int                COL_BITS   = 7,
    parameter int                DATA_W     = 8,
    parameter bit                ROW_HIGH   = 1'b1,
    parameter logic [DATA_W-1:0] BACKGROUND = '0,
    localparam int               ADDR_W     = ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail_phase,
    output logic [2:0]        fail_step,
    output logic [ADDR_W-1:0] fail_index,
    output logic [DATA_W-1:0] fail_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata
);
    localparam logic [ADDR_W-1:0] CELL_LAST = '1;
    localparam logic [ADDR_W-1:0] ROW_LAST  = {{COL_BITS{1'b0}}, {ROW_BITS{1'b1}}};

    fsm_e              fsm_q;
    step_e             step_q;
    logic              phase_q;
    logic              done_q, pass_q;
    logic              fphase_q;
    logic [2:0]        fstep_q;
    logic [ADDR_W-1:0] findex_q;
    logic [DATA_W-1:0] fdata_q;

    cmd_kind_e         kind;
    logic [ADDR_W-1:0] idx;
    logic              at_last;
    logic              adv, launch, mismatch;
    logic              idx_clear, idx_inc;
    logic [DATA_W-1:0] wdata_val, expect_val;

    assign kind     = step_kind(step_q);
    assign launch   = start && (fsm_q == FSM_IDLE || fsm_q == FSM_DONE);
    assign mismatch = rsp_rdata != expect_val;

    always_comb begin
        adv = 1'b0;
        if (fsm_q == FSM_ISSUE && cmd_ready && kind == KIND_WRITE) begin
            adv = 1'b1;
        end else if (fsm_q == FSM_WAIT && rsp_valid && !mismatch) begin
            adv = 1'b1;
        end
    end

    assign idx_clear = launch || (adv && at_last);
    assign idx_inc   = adv && !at_last;

    rcm_index_ctr #(.W(ADDR_W)) idx_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (idx_clear),
        .inc    (idx_inc),
        .last   ((step_q == ST_FILL) ? CELL_LAST : ROW_LAST),
        .value  (idx),
        .at_last(at_last)
    );

    rcm_addr_map #(
        .ROW_BITS(ROW_BITS),
        .COL_BITS(COL_BITS),
        .ROW_HIGH(ROW_HIGH)
    ) map_i (
        .idx   (idx),
        .kind  (kind),
        .linear(step_q == ST_FILL),
        .addr  (cmd_addr)
    );

    rcm_pattern #(.DATA_W(DATA_W), .BACKGROUND(BACKGROUND)) wpat_i (
        .phase (phase_q),
        .invert(wdata_inverted(step_q)),
        .value (wdata_val)
    );

    rcm_pattern #(.DATA_W(DATA_W), .BACKGROUND(BACKGROUND)) epat_i (
        .phase (phase_q),
        .invert(expect_inverted(step_q)),
        .value (expect_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q    <= FSM_IDLE;
            step_q   <= ST_FILL;
            phase_q  <= 1'b0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            fphase_q <= 1'b0;
            fstep_q  <= '0;
            findex_q <= '0;
            fdata_q  <= '0;
        end else if (launch) begin
            fsm_q    <= FSM_ISSUE;
            step_q   <= ST_FILL;
            phase_q  <= 1'b0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            fphase_q <= 1'b0;
            fstep_q  <= '0;
            findex_q <= '0;
            fdata_q  <= '0;
        end else if (adv) begin
            fsm_q <= FSM_ISSUE;
            if (at_last) begin
                if (step_q == ST_CHK_B) begin
                    if (phase_q) begin
                        fsm_q  <= FSM_DONE;
                        done_q <= 1'b1;
                        pass_q <= 1'b1;
                    end else begin
                        phase_q <= 1'b1;
                        step_q  <= ST_FILL;
                    end
                end else begin
                    step_q <= next_step(step_q);
                end
            end
        end else begin
            case (fsm_q)
                FSM_ISSUE: begin
                    if (cmd_ready) begin
                        fsm_q <= FSM_WAIT;
                    end
                end
                FSM_WAIT: begin
                    if (rsp_valid) begin
                        fsm_q    <= FSM_DONE;
                        done_q   <= 1'b1;
                        pass_q   <= 1'b0;
                        fphase_q <= phase_q;
                        fstep_q  <= step_q;
                        findex_q <= idx;
                        fdata_q  <= rsp_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy       = (fsm_q == FSM_ISSUE) || (fsm_q == FSM_WAIT);
    assign done       = done_q;
    assign pass       = pass_q;
    assign fail_phase = fphase_q;
    assign fail_step  = fstep_q;
    assign fail_index = findex_q;
    assign fail_data  = fdata_q;
    assign cmd_valid  = (fsm_q == FSM_ISSUE);
    assign cmd_kind   = kind;
    assign cmd_wdata  = wdata_val;
endmodule

// File: rtl/rcm_march_checker.sv
module rcm_march_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [2:0]        fail_step,
    input logic [ADDR_W-1:0] fail_index,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              rsp_valid
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (cmd_valid && cmd_ready && cmd_kind != 2'd0) begin
            pending <= 1'b1;
        end else if (rsp_valid) begin
            pending <= 1'b0;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cmd_valid && !busy && !done && !pass));

    a_r2_kind_legal: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_kind != 2'd3));

    a_r3_ctr_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd2) |-> (cmd_addr == '0));

    a_r7_silent_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cmd_valid && !busy));

    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_step) && $stable(fail_index)));

    a_r8_pass_implies_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    a_r9_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    a_r10_hold_payload: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_wdata)));

    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (rst)
        pending |-> !cmd_valid);
endmodule

bind rcm_march_top rcm_march_checker #(
    .ADDR_W(ROW_BITS + COL_BITS),
    .DATA_W(DATA_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail_step (fail_step),
    .fail_index(fail_index),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .rsp_valid (rsp_valid)
);

// File: tb/rcm_march_top_tb_top.sv
module rcm_march_top_tb_top;
    localparam int            RB    = 5;
    localparam int            CB    = 3;
    localparam int            DW    = 8;
    localparam bit            RH    = 1'b0;
    localparam logic [DW-1:0] BG    = 8'h00;
    localparam int            AW    = RB + CB;
    localparam int            CELLS = 1 << AW;
    localparam int            ROWS  = 1 << RB;
    localparam int            PER   = CELLS + 4 * ROWS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, done, pass, fail_phase;
    logic [2:0]    fail_step;
    logic [AW-1:0] fail_index;
    logic [DW-1:0] fail_data;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic          rsp_valid = 1'b0;
    logic [DW-1:0] rsp_rdata = '0;

    always #5 clk = ~clk;

    rcm_march_top #(
        .ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW), .ROW_HIGH(RH), .BACKGROUND(BG)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
        .fail_phase(fail_phase), .fail_step(fail_step), .fail_index(fail_index),
        .fail_data(fail_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int failures = 0;

    // Host controller model state
    logic [DW-1:0] mem [CELLS];
    int            ctr_row;
    int            ctr_stride;
    int            flt_addr;
    logic [DW-1:0] flt_or, flt_and;
    int            rdy_pct;
    bit            pend;
    int            dly;
    logic [DW-1:0] pdata;
    int            seq_n;
    int            seq_errs;
    string         seq_msg;

    function automatic int col0_addr(int row);
        return RH ? (row << CB) : row;
    endfunction

    function automatic logic [DW-1:0] host_read(int a);
        if (a == flt_addr) return (mem[a] | flt_or) & flt_and;
        return mem[a];
    endfunction

    // Expected command n of a run (R2..R6)
    function automatic void exp_cmd(int n, output int kind, output int addr, output logic [DW-1:0] wd);
        int ph, r, s, i;
        logic [DW-1:0] d;
        ph = n / PER;
        r  = n % PER;
        d  = ph[0] ? ~BG : BG;
        if (r < CELLS) begin
            kind = 0; addr = r; wd = d;
        end else begin
            r = r - CELLS;
            s = r / ROWS;
            i = r % ROWS;
            case (s)
                0:       begin kind = 2; addr = 0;            wd = ~d; end
                1:       begin kind = 1; addr = col0_addr(i); wd = '0; end
                2:       begin kind = 2; addr = 0;            wd = d;  end
                default: begin kind = 1; addr = col0_addr(i); wd = '0; end
            endcase
        end
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            cmd_ready = 1'b0;
            rsp_valid = 1'b0;
            pend = 1'b0;
        end else begin
            bit r;
            rsp_valid = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    rsp_valid = 1'b1;
                    rsp_rdata = pdata;
                    pend = 1'b0;
                end else begin
                    dly = dly - 1;
                end
            end
            r = (int'($urandom % 100) < rdy_pct);
            if (cmd_valid && r) begin
                int ek, ea;
                logic [DW-1:0] ew;
                exp_cmd(seq_n, ek, ea, ew);
                if (seq_n >= 2 * PER || int'(cmd_kind) != ek ||
                    (ek != 1 && cmd_wdata != ew) || int'(cmd_addr) != ea) begin
                    if (seq_errs == 0)
                        $sformat(seq_msg, "cmd %0d: kind=%0d addr=%0d wdata=%0h, expected kind=%0d addr=%0d wdata=%0h",
                                 seq_n, cmd_kind, cmd_addr, cmd_wdata, ek, ea, ew);
                    seq_errs++;
                end
                seq_n++;
                if (cmd_kind == 2'd0) begin
                    mem[int'(cmd_addr)] = cmd_wdata;
                end else if (cmd_kind == 2'd1) begin
                    pdata = host_read(int'(cmd_addr));
                    pend = 1'b1;
                    dly = int'($urandom % 3);
                end else begin
                    int a;
                    a = col0_addr(ctr_row);
                    pdata = host_read(a);
                    mem[a] = cmd_wdata;
                    ctr_row = (ctr_row + ctr_stride) % ROWS;
                    pend = 1'b1;
                    dly = int'($urandom % 3);
                end
            end
            cmd_ready = r;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One run: expected outcome computed from the requirements
    task automatic run(string name, int c0, int stride, int faddr, logic [DW-1:0] f_or,
                       logic [DW-1:0] f_and, bit exp_pass, int exp_step, int exp_phase,
                       int exp_idx, int exp_data, int exp_cmds, bit mid_start);
        int k;
        for (int a = 0; a < CELLS; a++) mem[a] = DW'($urandom);
        ctr_row = c0; ctr_stride = stride;
        flt_addr = faddr; flt_or = f_or; flt_and = f_and;
        rdy_pct = 40 + int'($urandom % 61);
        seq_n = 0; seq_errs = 0; seq_msg = "";
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        k = 0;
        while (!done && k < 40000) begin
            @(negedge clk);
            k++;
            if (mid_start && k == 300) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        check(done == 1'b1, "R7", {name, " watchdog/done"}, int'(done), 1);
        check(pass == exp_pass, exp_pass ? "R8" : "R7", {name, " pass"}, int'(pass), int'(exp_pass));
        check(int'(fail_step) == exp_step, "R7", {name, " fail_step"}, int'(fail_step), exp_step);
        if (!exp_pass) begin
            check(int'(fail_phase) == exp_phase, "R7", {name, " fail_phase"}, int'(fail_phase), exp_phase);
            check(int'(fail_index) == exp_idx, "R7", {name, " fail_index"}, int'(fail_index), exp_idx);
            check(int'(fail_data) == exp_data, "R7", {name, " fail_data"}, int'(fail_data), exp_data);
        end
        repeat (5) @(negedge clk);
        check(seq_n == exp_cmds, exp_pass ? "R8" : "R7", {name, " command count"}, seq_n, exp_cmds);
        if (seq_errs != 0) $display("  first stream error: %s", seq_msg);
        check(seq_errs == 0, mid_start ? "R9" : "R2", {name, " command stream"}, seq_errs, 0);
        if (exp_pass) begin
            int bad;
            bad = 0;
            for (int a = 0; a < CELLS; a++) if (mem[a] != ~BG) bad++;
            check(bad == 0, "R6", {name, " final image complemented"}, bad, 0);
        end
    endtask

    initial begin
        int c0;
        rdy_pct = 70; ctr_stride = 1; ctr_row = 0; flt_addr = -1; flt_or = '0; flt_and = '1;
        seq_n = 0; seq_errs = 0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !pass && !cmd_valid, "R1", "idle after reset",
              int'({busy, done, pass, cmd_valid}), 0);

        // R3 R4 R5 R8: clean runs with random start row and handshake delays
        for (int t = 0; t < 3; t++) begin
            c0 = int'($urandom % ROWS);
            run("clean", c0, 1, -1, '0, '1, 1'b1, 0, 0, 0, 0, 2 * PER, 1'b0);
        end
        // R9: start pulsed mid-run is ignored
        run("mid_start", 7, 1, -1, '0, '1, 1'b1, 0, 0, 0, 0, 2 * PER, 1'b1);
        // R3 R7: stuck-at-1 in column zero, seen in the first counter lap
        c0 = int'($urandom % ROWS);
        run("stuck1", c0, 1, col0_addr(5), 8'h01, 8'hFF, 1'b0, 2, 0,
            (5 - c0 + ROWS) % ROWS, 8'h01, CELLS + ((5 - c0 + ROWS) % ROWS) + 1, 1'b0);
        // R4 R7: stuck-at-0 in column zero, seen in the first normal check
        run("stuck0", 3, 1, col0_addr(9), 8'h00, 8'h7F, 1'b0, 3, 0, 9, 8'h7F,
            CELLS + ROWS + 10, 1'b0);
        // R3: counter revisits rows (stride 2)
        run("stride2", 11, 2, -1, '0, '1, 1'b0, 2, 0, ROWS / 2, 8'hFF, CELLS + ROWS / 2 + 1, 1'b0);
        // R3: counter stalls
        run("stall", 20, 0, -1, '0, '1, 1'b0, 2, 0, 1, 8'hFF, CELLS + 2, 1'b0);
        // R4: fault outside column zero is never read
        run("offcol", 0, 1, col0_addr(3) + (RH ? 2 : (2 << RB)), 8'h81, 8'hFF, 1'b1, 0, 0, 0, 0,
            2 * PER, 1'b0);
        // R5 R6: clean run again after failures (restart from done)
        run("restart", int'($urandom % ROWS), 1, -1, '0, '1, 1'b1, 0, 0, 0, 0, 2 * PER, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule